// File: doc/BRIEF.md
# Audio Rail Power Sequencer

This block brings up and shuts down four audio supply domains in a fixed order: the reference/bias domain, the analog rail, the digital rail and the amplifier power rail. It also drives the amplifier's mute and enable lines. It runs on a millisecond tick divided down from the system clock. It raises one rail enable at a time. The next rail waits until the previous rail's filtered power-good has been seen and a settling delay has elapsed. Each rail ramps within a programmable window, and the amplifier stays muted until every rail is up and the amplifier itself has been enabled.

Shutdown is triggered in one of three ways: by dropping the master enable, by an undervoltage that lasts longer than a hold time, or by a fault. The amplifier is muted first. The rails are then ramped down from the top of the order to the bottom. A timed-out power-good or an external fault latches a sticky fault flag, which only a low master enable clears. After any shutdown, a hold-off delay must expire before the next power-up starts. This keeps residual charge from disturbing the order.

Top module: `audio_rail_seq`

## Requirements
- R1: Rail enables are nested in the fixed order 0 (reference/bias), 1 (analog), 2 (digital), 3 (amplifier power). A rail is never enabled while a rail below it is disabled.
- R2: Rail i+1 is enabled only after rail i's filtered power-good is high. At least SETTLE_MS further ticks must also have passed, so the gap from rail i's raw power-good rising to rail i+1 enabling is at least (DGL_TICKS+SETTLE_MS-2) ticks.
- R3: Amplifier mute is high whenever any ramp-active flag is high. It is also high in every state other than fully powered.
- R4: Each ramp window lasts L ticks, where L is `ramp_ms` clamped to the range 5 to 20.
- R5: Amplifier enable rises only after rail 3 has settled, and at least one tick before mute falls. Mute falls together with the rise of global power-good.
- R6: When the master enable drops, mute rises first. Rails 3, 2, 1 and 0 then disable in that order, one ramp window each. Global power-good falls only after rail 0's ramp-down ends.
- R7: An undervoltage input held high for UV_HOLD_MS ticks drops global power-good, forces mute and ramps all rails down. A shorter pulse has no effect. Once the input returns low, the full power-up sequence runs again.
- R8: Each power-good input is synchronised and filtered. A level change that lasts fewer than DGL_TICKS ticks is ignored.
- R9: After a shutdown completes, no rail is enabled until HOLDOFF_MS ticks have passed, even if the master enable is already high.
- R10: A high `fault_in`, or a power-good that stays low for PG_TOUT_MS ticks after its ramp, sets `fault_flag` and forces a muted reverse shutdown. The block then stays down with the flag set until `sys_en` is low.
- R11: While reset is held, all rail enables, ramp flags, amplifier enable, power-good and fault flag are low, and mute is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sys_en | input | 1 | Master enable; low requests shutdown and clears the fault flag |
| ramp_ms | input | RW | Ramp window in ticks, clamped to 5..20 |
| rail_pg | input | NRAIL | Raw per-rail power-good from the regulators |
| uv_in | input | 1 | Undervoltage comparator output |
| fault_in | input | 1 | External fault request |
| rail_en | output | NRAIL | Per-rail enable, bit 0 = reference/bias |
| rail_ramp | output | NRAIL | Per-rail ramp-in-progress flag |
| amp_mute | output | 1 | Amplifier mute, high = muted |
| amp_en | output | 1 | Amplifier enable |
| pwr_good | output | 1 | Global power-good |
| fault_flag | output | 1 | Sticky fault indication |

## Verification
Several rules are checked on every cycle:
- rails stay nested;
- mute is held during every ramp;
- unmute happens only with the amplifier enabled and power-good high;
- each rail is released only behind the previous rail's filtered power-good;
- the filtered power-good changes only on a tick;
- the fault flag stays set while the enable is high.

Other behaviour only shows up over the bench's scenarios, because it spans many ticks:
- the measured ramp lengths for clamped and in-range settings;
- the settling gap;
- the reverse shutdown order;
- the hold-off delay on a hot restart;
- the rejection of short undervoltage and power-good pulses;
- the timeout path into the fault state.

// File: rtl/aseq_pkg.sv
// Shared types for the audio rail sequencer.
// Assumes: one controller instance per set of four audio rails.
package aseq_pkg;

    typedef enum logic [3:0] {
        S_OFF,        // all rails down, waiting for enable and hold-off
        S_PREMUTE,    // mute asserted, one tick before the first ramp
        S_UP_RAMP,    // rail idx enabled and ramping
        S_UP_WAIT,    // waiting for rail idx filtered power-good
        S_UP_SETTLE,  // settling after rail idx power-good
        S_AMP_ON,     // amplifier enabled, still muted
        S_RUN,        // fully powered, unmuted
        S_DN_MUTE,    // mute asserted before ramp-down
        S_DN_RAMP,    // rail idx disabled and ramping down
        S_FLT_HOLD    // down after fault, waiting for enable low
    } seq_state_t;

endpackage

// File: rtl/aseq_tick.sv
// Millisecond tick generator.
// Produces a one-cycle pulse every DIV clock cycles. Assumes DIV >= 2.
module aseq_tick #(
    parameter int DIV = 125000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = $clog2(DIV) + 1;

    logic [CW-1:0] div_cnt;

    // Count clock cycles and emit a pulse on wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_cnt <= '0;
            tick    <= 1'b0;
        end else if (div_cnt == CW'(DIV - 1)) begin
            div_cnt <= '0;
            tick    <= 1'b1;
        end else begin
            div_cnt <= div_cnt + 1'b1;
            tick    <= 1'b0;
        end
    end

    assert_tick_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/aseq_deglitch.sv
// Power-good filter for one rail.
// Synchronises the raw input with two flops. The filtered level follows the
// synchronised level only after it has differed for DGL ticks in a row.
// Assumes DGL >= 1 and a tick pulse one cycle wide.
module aseq_deglitch #(
    parameter int DGL = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic raw,
    output logic filt
);
    localparam int CW = $clog2(DGL + 1);

    logic          sync1, sync2;
    logic [CW-1:0] diff_cnt;

    // Synchronise, then count ticks of disagreement before following.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1    <= 1'b0;
            sync2    <= 1'b0;
            filt     <= 1'b0;
            diff_cnt <= '0;
        end else begin
            sync1 <= raw;
            sync2 <= sync1;
            if (sync2 == filt) begin
                diff_cnt <= '0;
            end else if (tick) begin
                if (diff_cnt == CW'(DGL - 1)) begin
                    filt     <= sync2;
                    diff_cnt <= '0;
                end else begin
                    diff_cnt <= diff_cnt + 1'b1;
                end
            end
        end
    end

    assert_filt_on_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(filt));

endmodule

// File: rtl/aseq_ctrl.sv
// Sequencing state machine for the audio rails.
// Raises rails upward behind filtered power-good plus a settling delay.
// Keeps the amplifier muted until everything is up. Lowers rails in reverse
// order on disable, brownout or fault.
// Assumes: tick is one cycle wide; pg_f is already filtered; NRAIL is a power of two.
module aseq_ctrl
    import aseq_pkg::*;
#(
    parameter int NRAIL       = 4,
    parameter int RW          = 5,
    parameter int RAMP_MIN_MS = 5,
    parameter int RAMP_MAX_MS = 20,
    parameter int SETTLE_MS   = 3,
    parameter int UV_HOLD_MS  = 4,
    parameter int HOLDOFF_MS  = 8,
    parameter int PG_TOUT_MS  = 30
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             sys_en,
    input  logic [RW-1:0]    ramp_ms,
    input  logic [NRAIL-1:0] pg_f,
    input  logic             uv_in,
    input  logic             fault_in,
    output logic [NRAIL-1:0] rail_en,
    output logic [NRAIL-1:0] rail_ramp,
    output logic             amp_mute,
    output logic             amp_en,
    output logic             pwr_good,
    output logic             fault_flag
);
    localparam int IW = $clog2(NRAIL);
    localparam int TW = $clog2(RAMP_MAX_MS + SETTLE_MS + UV_HOLD_MS + HOLDOFF_MS + PG_TOUT_MS + 1) + 1;

    seq_state_t    state;
    logic [IW-1:0] idx;
    logic [TW-1:0] cnt, hoff, uv_cnt, ramp_len;
    logic          pg_q, fault_q;
    logic          active, uv_trip, to_hit, abort_flt, abort_any;

    // Clamp the requested ramp window to the legal range.
    always_comb begin
        if (ramp_ms < RW'(RAMP_MIN_MS))      ramp_len = TW'(RAMP_MIN_MS);
        else if (ramp_ms > RW'(RAMP_MAX_MS)) ramp_len = TW'(RAMP_MAX_MS);
        else                                 ramp_len = TW'(ramp_ms);
    end

    // Measure how long the undervoltage input has stayed high, in ticks.
    always_ff @(posedge clk) begin
        if (!rst_n)                                      uv_cnt <= '0;
        else if (!uv_in)                                 uv_cnt <= '0;
        else if (tick && uv_cnt != TW'(UV_HOLD_MS))      uv_cnt <= uv_cnt + 1'b1;
    end

    // Decode the abort conditions that apply while powering up or running.
    always_comb begin
        active    = (state == S_PREMUTE) || (state == S_UP_RAMP) || (state == S_UP_WAIT) ||
                    (state == S_UP_SETTLE) || (state == S_AMP_ON) || (state == S_RUN);
        uv_trip   = (uv_cnt == TW'(UV_HOLD_MS));
        to_hit    = (state == S_UP_WAIT) && tick && !pg_f[idx] && (cnt == TW'(PG_TOUT_MS - 1));
        abort_flt = active && (fault_in || to_hit);
        abort_any = active && (abort_flt || uv_trip || !sys_en);
    end

    // Main sequencing process: state, rail index, tick timer, hold-off and flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_OFF;
            idx     <= '0;
            cnt     <= '0;
            hoff    <= '0;
            pg_q    <= 1'b0;
            fault_q <= 1'b0;
        end else begin
            if (tick && cnt != '1) cnt  <= cnt + 1'b1;
            if (tick && hoff != '0) hoff <= hoff - 1'b1;
            if (abort_any) begin
                cnt     <= '0;
                fault_q <= fault_q | abort_flt;
                if (abort_flt || uv_trip) pg_q <= 1'b0;
                if (state == S_PREMUTE) begin
                    if (abort_flt || fault_q) begin
                        state <= S_FLT_HOLD;
                    end else begin
                        state <= S_OFF;
                        hoff  <= TW'(HOLDOFF_MS);
                    end
                end else begin
                    state <= S_DN_MUTE;
                end
            end else begin
                case (state)
                    S_OFF: if (sys_en && !uv_in && hoff == '0) begin
                        state <= S_PREMUTE;
                        idx   <= '0;
                        cnt   <= '0;
                    end
                    S_PREMUTE: if (tick) begin
                        state <= S_UP_RAMP;
                        cnt   <= '0;
                    end
                    S_UP_RAMP: if (tick && cnt == ramp_len - TW'(1)) begin
                        state <= S_UP_WAIT;
                        cnt   <= '0;
                    end
                    S_UP_WAIT: if (pg_f[idx]) begin
                        state <= S_UP_SETTLE;
                        cnt   <= '0;
                    end
                    S_UP_SETTLE: if (!pg_f[idx]) begin
                        state <= S_UP_WAIT;
                        cnt   <= '0;
                    end else if (tick && cnt == TW'(SETTLE_MS - 1)) begin
                        cnt <= '0;
                        if (idx == IW'(NRAIL - 1)) begin
                            state <= S_AMP_ON;
                        end else begin
                            idx   <= idx + 1'b1;
                            state <= S_UP_RAMP;
                        end
                    end
                    S_AMP_ON: if (tick) begin
                        state <= S_RUN;
                        pg_q  <= 1'b1;
                    end
                    S_DN_MUTE: if (tick) begin
                        state <= S_DN_RAMP;
                        cnt   <= '0;
                    end
                    S_DN_RAMP: if (tick && cnt == ramp_len - TW'(1)) begin
                        cnt <= '0;
                        if (idx == '0) begin
                            pg_q <= 1'b0;
                            if (fault_q) begin
                                state <= S_FLT_HOLD;
                            end else begin
                                state <= S_OFF;
                                hoff  <= TW'(HOLDOFF_MS);
                            end
                        end else begin
                            idx <= idx - 1'b1;
                        end
                    end
                    S_FLT_HOLD: if (!sys_en) begin
                        fault_q <= 1'b0;
                        state   <= S_OFF;
                        hoff    <= TW'(HOLDOFF_MS);
                    end
                    default: ;
                endcase
            end
        end
    end

    // Drive rail enables and ramp flags from the state and rail index.
    always_comb begin
        for (int i = 0; i < NRAIL; i++) begin
            case (state)
                S_UP_RAMP, S_UP_WAIT, S_UP_SETTLE, S_DN_MUTE: rail_en[i] = (IW'(i) <= idx);
                S_AMP_ON, S_RUN:                              rail_en[i] = 1'b1;
                S_DN_RAMP:                                    rail_en[i] = (IW'(i) < idx);
                default:                                      rail_en[i] = 1'b0;
            endcase
            rail_ramp[i] = ((state == S_UP_RAMP) || (state == S_DN_RAMP)) && (idx == IW'(i));
        end
        amp_en     = (state == S_AMP_ON) || (state == S_RUN);
        amp_mute   = (state != S_RUN);
        pwr_good   = pg_q;
        fault_flag = fault_q;
    end

    assert_mute_during_ramp_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|rail_ramp) |-> amp_mute);

    assert_unmute_needs_amp_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !amp_mute |-> (amp_en && pwr_good));

    assert_fault_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_flag && sys_en) |=> fault_flag);

    assert_brownout_drops_pg_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (active && uv_trip) |=> !pwr_good);

    for (genvar g = 1; g < NRAIL; g++) begin : g_chk
        assert_nested_en_R1: assert property (@(posedge clk) disable iff (!rst_n)
            rail_en[g] |-> rail_en[g-1]);
        assert_pg_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(rail_en[g]) |-> $past(pg_f[g-1]));
    end

endmodule

// File: rtl/audio_rail_seq.sv
// Audio rail power sequencer, top level.
// Ties together the tick divider, one power-good filter per rail and the
// sequencing state machine.
// Assumes: the analog side supplies raw power-good, undervoltage and fault
// levels; all timing parameters are counted in ticks.
module audio_rail_seq #(
    parameter int TICK_DIV    = 125000,
    parameter int NRAIL       = 4,
    parameter int RW          = 5,
    parameter int RAMP_MIN_MS = 5,
    parameter int RAMP_MAX_MS = 20,
    parameter int SETTLE_MS   = 3,
    parameter int DGL_TICKS   = 3,
    parameter int UV_HOLD_MS  = 4,
    parameter int HOLDOFF_MS  = 8,
    parameter int PG_TOUT_MS  = 30
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sys_en,
    input  logic [RW-1:0]    ramp_ms,
    input  logic [NRAIL-1:0] rail_pg,
    input  logic             uv_in,
    input  logic             fault_in,
    output logic [NRAIL-1:0] rail_en,
    output logic [NRAIL-1:0] rail_ramp,
    output logic             amp_mute,
    output logic             amp_en,
    output logic             pwr_good,
    output logic             fault_flag
);
    logic             ms_tick;
    logic [NRAIL-1:0] pg_filt;

    aseq_tick #(.DIV(TICK_DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (ms_tick)
    );

    for (genvar r = 0; r < NRAIL; r++) begin : g_pg
        aseq_deglitch #(.DGL(DGL_TICKS)) u_dgl (
            .clk  (clk),
            .rst_n(rst_n),
            .tick (ms_tick),
            .raw  (rail_pg[r]),
            .filt (pg_filt[r])
        );
    end

    aseq_ctrl #(
        .NRAIL      (NRAIL),
        .RW         (RW),
        .RAMP_MIN_MS(RAMP_MIN_MS),
        .RAMP_MAX_MS(RAMP_MAX_MS),
        .SETTLE_MS  (SETTLE_MS),
        .UV_HOLD_MS (UV_HOLD_MS),
        .HOLDOFF_MS (HOLDOFF_MS),
        .PG_TOUT_MS (PG_TOUT_MS)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (ms_tick),
        .sys_en    (sys_en),
        .ramp_ms   (ramp_ms),
        .pg_f      (pg_filt),
        .uv_in     (uv_in),
        .fault_in  (fault_in),
        .rail_en   (rail_en),
        .rail_ramp (rail_ramp),
        .amp_mute  (amp_mute),
        .amp_en    (amp_en),
        .pwr_good  (pwr_good),
        .fault_flag(fault_flag)
    );

endmodule

// File: tb/test_audio_rail_seq.sv
// Bench for the audio rail sequencer.
// A table of ramp settings drives full power cycles. Directed tests then cover
// reset, hot start, brownout, power-good glitch, timeout and external fault.
module test_audio_rail_seq;
    localparam int D     = 4;
    localparam int DGL   = 3;
    localparam int SETL  = 3;
    localparam int UVH   = 4;
    localparam int HOFF  = 8;
    localparam int TOUT  = 30;
    localparam int PDLY  = 6;
    localparam int NV    = 5;
    localparam int VEC [NV][2] = '{'{3, 5}, '{5, 5}, '{12, 12}, '{20, 20}, '{25, 20}};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sys_en = 1'b0;
    logic [4:0] ramp_ms = 5'd5;
    logic [3:0] rail_pg;
    logic       uv_in = 1'b0;
    logic       fault_in = 1'b0;
    logic [3:0] rail_en, rail_ramp;
    logic       amp_mute, amp_en, pwr_good, fault_flag;

    logic [3:0] blk = 4'b0000;
    logic [3:0] glitch = 4'b0000;
    logic [3:0] pg_model;
    int         dly [4];

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    int cyc = 0;
    int viol_mute = 0, viol_order = 0, viol_gate = 0, viol_unmute = 0;
    int t_fall [4];
    int t_pgrise [4];
    int gap [4];
    int t_mute_rise = 0, t_pg_fall = 0;
    int ramp_w = 0, ramp_run = 0;
    logic [3:0] en_d = 4'b0000, pg_d = 4'b0000;
    logic mute_d = 1'b1, pgood_d = 1'b0, r0_d = 1'b0;

    always #4 clk = ~clk;

    audio_rail_seq #(
        .TICK_DIV(D), .SETTLE_MS(SETL), .DGL_TICKS(DGL), .UV_HOLD_MS(UVH),
        .HOLDOFF_MS(HOFF), .PG_TOUT_MS(TOUT)
    ) i_audio_rail_seq (
        .clk(clk), .rst_n(rst_n), .sys_en(sys_en), .ramp_ms(ramp_ms),
        .rail_pg(rail_pg), .uv_in(uv_in), .fault_in(fault_in),
        .rail_en(rail_en), .rail_ramp(rail_ramp), .amp_mute(amp_mute),
        .amp_en(amp_en), .pwr_good(pwr_good), .fault_flag(fault_flag)
    );

    assign rail_pg = (pg_model & ~blk) | glitch;

    // Regulator model: power-good follows enable after PDLY cycles.
    always @(negedge clk) begin
        for (int i = 0; i < 4; i++) begin
            if (!rail_en[i]) begin
                dly[i]      <= 0;
                pg_model[i] <= 1'b0;
            end else if (dly[i] < PDLY) begin
                dly[i] <= dly[i] + 1;
            end else begin
                pg_model[i] <= 1'b1;
            end
        end
    end

    // Cycle monitor: order, mute, gating and timing stamps.
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (rst_n) begin
            if ((|rail_ramp) && !amp_mute) viol_mute = viol_mute + 1;          // R3
            if (!amp_mute && !amp_en) viol_unmute = viol_unmute + 1;           // R5
            for (int i = 1; i < 4; i++) begin
                if (rail_en[i] && !rail_en[i-1]) viol_order = viol_order + 1;  // R1
                if (rail_en[i] && !en_d[i]) begin
                    if (!pg_d[i-1]) viol_gate = viol_gate + 1;                 // R2
                    gap[i-1] = cyc - t_pgrise[i-1];
                end
            end
            for (int i = 0; i < 4; i++) begin
                if (!rail_en[i] && en_d[i]) t_fall[i] = cyc;
                if (rail_pg[i] && !pg_d[i]) t_pgrise[i] = cyc;
            end
            if (amp_mute && !mute_d) t_mute_rise = cyc;
            if (!pwr_good && pgood_d) t_pg_fall = cyc;
            if (rail_ramp[0] && rail_en[0]) ramp_run = ramp_run + 1;
            else if (r0_d && ramp_run > 0) begin ramp_w = ramp_run; ramp_run = 0; end
            r0_d = rail_ramp[0] && rail_en[0];
        end
        en_d = rail_en; pg_d = rail_pg; mute_d = amp_mute; pgood_d = pwr_good;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    function automatic bit sel(input int which);
        case (which)
            0: return pwr_good;
            1: return rail_en[0];
            2: return fault_flag;
            3: return (rail_en == 4'b0000);
            default: return rail_en[1];
        endcase
    endfunction

    task automatic wait_sig(input int which, input bit lvl, input int lim, output int n);
        n = 0;
        while (sel(which) != lvl && n < lim) begin
            step(1);
            n = n + 1;
        end
    endtask

    task automatic shut_down(input string req);
        int n;
        sys_en = 1'b0;
        wait_sig(0, 1'b0, 3000, n);
        chk(n < 3000 && rail_en == 4'b0000, req, int'(rail_en), 0);
        step(2);
    endtask

    initial begin
        int n, cold_n, L;
        step(5);
        chk(rail_en == 4'b0000 && rail_ramp == 4'b0000, "R11 rails", int'({rail_en, rail_ramp}), 0);
        chk(amp_mute == 1'b1, "R11 mute", int'(amp_mute), 1);
        chk(amp_en == 1'b0, "R11 amp_en", int'(amp_en), 0);
        chk(pwr_good == 1'b0 && fault_flag == 1'b0, "R11 flags", int'({pwr_good, fault_flag}), 0);
        rst_n = 1'b1;
        cold_n = 0;

        for (int v = 0; v < NV; v++) begin
            ramp_ms = 5'(VEC[v][0]);
            L = VEC[v][1];
            step((HOFF + 2) * D);
            sys_en = 1'b1;
            wait_sig(1, 1'b1, 200, n);
            if (v == 0) cold_n = n;
            wait_sig(0, 1'b1, 5000, n);
            chk(n < 5000, "R5 power-up completes", n, 0);
            chk(amp_en && !amp_mute, "R5 amp live", int'({amp_en, amp_mute}), 2);
            chk(ramp_w >= L * D - 1 && ramp_w <= L * D + 1, "R4 ramp width", ramp_w, L * D);
            if (v == 0) begin
                for (int i = 0; i < 3; i++)
                    chk(gap[i] >= (DGL + SETL - 2) * D && gap[i] <= (DGL + SETL) * D + 6,
                        "R2 settle gap", gap[i], (DGL + SETL) * D);
            end
            shut_down("R6 shutdown");
            chk(t_mute_rise < t_fall[3] && t_fall[3] < t_fall[2] && t_fall[2] < t_fall[1] &&
                t_fall[1] < t_fall[0] && t_fall[0] < t_pg_fall, "R6 order",
                t_fall[0], t_pg_fall);
        end
        chk(cold_n <= 2 * D + 2, "R9 cold start delay", cold_n, 2 * D);

        // R9 hot start: enable right after shutdown completes.
        sys_en = 1'b1;
        wait_sig(1, 1'b1, 500, n);
        chk(n >= (HOFF - 1) * D, "R9 hot-start hold-off", n, HOFF * D);
        wait_sig(0, 1'b1, 5000, n);
        chk(pwr_good == 1'b1, "R9 power-up after hold-off", int'(pwr_good), 1);

        // R7 short undervoltage is ignored.
        uv_in = 1'b1; step(2 * D - 1); uv_in = 1'b0;
        step(10 * D);
        chk(pwr_good && !amp_mute && rail_en == 4'hF, "R7 short dip ignored",
            int'({pwr_good, amp_mute, rail_en}), 'h2F);
        // R7 long undervoltage.
        uv_in = 1'b1;
        step((UVH + 2) * D);
        chk(!pwr_good && amp_mute, "R7 brownout pg/mute", int'({pwr_good, amp_mute}), 1);
        wait_sig(3, 1'b1, 3000, n);
        chk(rail_en == 4'b0000, "R7 rails down", int'(rail_en), 0);
        uv_in = 1'b0;
        wait_sig(0, 1'b1, 5000, n);
        chk(pwr_good == 1'b1, "R7 restart after recovery", int'(pwr_good), 1);

        // R10 external fault.
        fault_in = 1'b1; step(1); fault_in = 1'b0;
        step(2);
        chk(fault_flag && !pwr_good, "R10 fault latch", int'({fault_flag, pwr_good}), 2);
        wait_sig(3, 1'b1, 3000, n);
        step(50 * D);
        chk(fault_flag && amp_mute && rail_en == 4'b0000, "R10 stays down",
            int'({fault_flag, amp_mute, rail_en}), 'h30);
        sys_en = 1'b0; step(2);
        chk(fault_flag == 1'b0, "R10 cleared by enable low", int'(fault_flag), 0);

        // R8 glitch on a held-low power-good, then R10 timeout.
        ramp_ms = 5'd5;
        step((HOFF + 2) * D);
        blk = 4'b0010;
        sys_en = 1'b1;
        wait_sig(4, 1'b1, 500, n);
        step(5 * D + 4 * D);
        glitch[1] = 1'b1; step(D); glitch[1] = 1'b0;
        step((DGL + SETL + 2) * D);
        chk(rail_en[2] == 1'b0, "R8 glitch ignored", int'(rail_en[2]), 0);
        wait_sig(2, 1'b1, TOUT * D + 200, n);
        chk(fault_flag == 1'b1, "R10 timeout fault", int'(fault_flag), 1);
        wait_sig(3, 1'b1, 3000, n);
        chk(rail_en == 4'b0000 && amp_mute, "R10 timeout shutdown", int'(rail_en), 0);
        sys_en = 1'b0; blk = 4'b0000; step(4);

        chk(viol_mute == 0, "R3 mute during ramps", viol_mute, 0);
        chk(viol_order == 0, "R1 nested enables", viol_order, 0);
        chk(viol_gate == 0, "R2 pg gating", viol_gate, 0);
        chk(viol_unmute == 0, "R5 unmute with amp enabled", viol_unmute, 0);

        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        #1;
        if (!done) begin
            done = 1'b1;
            total = total + 1;
            bad = bad + 1;
            $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule